// File: doc/BRIEF.md
# USART Data Register Stage

This block sits between the processor bus and the serial engines of a USART. One bus location serves both directions. A read returns the byte held in the receive buffer. A write places a byte in the transmit buffer. The receive shift logic delivers each finished character with a one-cycle completion strobe and two per-character error bits. The block latches the character, raises a full flag and, when enabled, a receive interrupt. A later bus read frees the buffer.

The transmit side holds one byte, marked by a full signal. The transmitter removes the byte with a one-cycle take strobe. Error flags for parity, framing and overrun accumulate until a dedicated clear strobe. While any error flag is set, the buffered byte is to be treated as unreliable, and a read does not release the interrupt.

Top module: `usart_data_reg`

## Requirements
- R1: After reset, bus_rdata, tx_data and all flags (rx_full, rx_irq, err_par, err_ovr, err_frm, tx_full) are 0.
- R2: A completion strobe `rx_done` while rx_full is 0 stores `rx_char` into the receive buffer and sets rx_full. bus_rdata shows the stored byte one cycle after the strobe.
- R3: When `char7` is 1 at the completion strobe, bit 7 of the stored byte is 0 and bits 6..0 follow `rx_char`.
- R4: A bus read with no completion in the same cycle clears rx_full in the next cycle. The buffer contents stay as they were.
- R5: When a character is stored and `rx_ie` is 1, rx_irq is 1 in the next cycle. When `rx_ie` is 0, storing a character does not raise rx_irq.
- R6: A bus read clears rx_irq only when `rx_ie` is 1 and none of err_par, err_ovr, err_frm is set at that edge. Otherwise rx_irq keeps its value.
- R7: A completion strobe while rx_full is 1 and no read is in the same cycle leaves the buffer unchanged and sets err_ovr.
- R8: err_par and err_frm take the OR of their value and `rx_perr`/`rx_ferr` of each stored character. Reads do not clear any error flag. `err_clr` clears all three flags, but an error arriving in the same cycle as `err_clr` is kept.
- R9: A bus read and a completion in the same cycle while rx_full is 1 store the new character. rx_full stays 1 and err_ovr is not set.
- R10: A bus write while tx_full is 0 loads `bus_wdata` into tx_data and sets tx_full. Writes never change bus_rdata.
- R11: A bus write while tx_full is 1 is ignored, even when `tx_take` arrives in the same cycle: tx_data is unchanged. `tx_take` while tx_full is 1 clears tx_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe of the shared data location |
| bus_wr | input | 1 | Write strobe of the shared data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Receive buffer contents |
| char7 | input | 1 | 1 selects 7-bit characters |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_done | input | 1 | One-cycle strobe: a character has completed |
| rx_char | input | 8 | Completed character from the shift register |
| rx_perr | input | 1 | Parity error of the completing character |
| rx_ferr | input | 1 | Framing error of the completing character |
| err_clr | input | 1 | Clears all error flags |
| rx_full | output | 1 | Receive buffer holds an unread character |
| rx_irq | output | 1 | Receive interrupt request |
| err_par | output | 1 | Sticky parity error flag |
| err_ovr | output | 1 | Sticky overrun error flag |
| err_frm | output | 1 | Sticky framing error flag |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_full | output | 1 | Transmit buffer holds a byte |
| tx_take | input | 1 | Transmitter accepts the byte |

## Verification
Two pairs of events can land on one edge. A processor read can meet a character completion, and a bus write can meet a transmitter take while the transmit buffer is full. Directed sequences set up each collision on purpose. The random phase also hits them often, because the read, completion and take strobes are driven with high probability. A bench model written from the requirements predicts every output on every cycle. The collisions are judged by whether the new character is kept without an overrun, and whether the stale transmit byte survives the ignored write.

// File: rtl/usart_dreg_pkg.sv
package usart_dreg_pkg;
  typedef struct packed {
    logic par;
    logic ovr;
    logic frm;
  } rx_err_t;
endpackage

// File: rtl/usart_rx_buf.sv
module usart_rx_buf
  import usart_dreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_char,
  input  logic          char7,
  input  logic          bus_rd,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          err_clr,
  output logic [DW-1:0] buf_q,
  output logic          full_q,
  output rx_err_t       err_q,
  output logic          load
);
  localparam int TOP = DW - 1;

  logic          overrun;
  logic [DW-1:0] masked;

  // a read in the same cycle frees the slot for the arriving character
  assign load    = rx_done && (!full_q || bus_rd);
  assign overrun = rx_done && full_q && !bus_rd;

  always_comb begin
    masked = rx_char;
    if (char7) masked[TOP] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      err_q  <= '0;
    end else begin
      if (load) buf_q <= masked;
      if (load)        full_q <= 1'b1;
      else if (bus_rd) full_q <= 1'b0;
      err_q.par <= (err_q.par & ~err_clr) | (load & rx_perr);
      err_q.frm <= (err_q.frm & ~err_clr) | (load & rx_ferr);
      err_q.ovr <= (err_q.ovr & ~err_clr) | overrun;
    end
  end
endmodule

// File: rtl/usart_rx_irq.sv
module usart_rx_irq (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic rx_ie,
  input  logic bus_rd,
  input  logic err_any,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)                                  irq_q <= 1'b0;
    else if (load && rx_ie)                   irq_q <= 1'b1;
    else if (bus_rd && rx_ie && !err_any)     irq_q <= 1'b0;
  end
endmodule

// File: rtl/usart_tx_buf.sv
module usart_tx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          tx_take,
  output logic [DW-1:0] data_q,
  output logic          full_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (bus_wr && !full_q) begin
      data_q <= bus_wdata;
      full_q <= 1'b1;
    end else if (tx_take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/usart_data_reg.sv
module usart_data_reg
  import usart_dreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          char7,
  input  logic          rx_ie,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          err_clr,
  output logic          rx_full,
  output logic          rx_irq,
  output logic          err_par,
  output logic          err_ovr,
  output logic          err_frm,
  output logic [DW-1:0] tx_data,
  output logic          tx_full,
  input  logic          tx_take
);
  rx_err_t err;
  logic    load;

  usart_rx_buf #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_char(rx_char),
    .char7(char7), .bus_rd(bus_rd), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .err_clr(err_clr), .buf_q(bus_rdata), .full_q(rx_full),
    .err_q(err), .load(load)
  );

  usart_rx_irq u_irq (
    .clk(clk), .rst(rst), .load(load), .rx_ie(rx_ie), .bus_rd(bus_rd),
    .err_any(|err), .irq_q(rx_irq)
  );

  usart_tx_buf #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .tx_take(tx_take), .data_q(tx_data), .full_q(tx_full)
  );

  assign err_par = err.par;
  assign err_ovr = err.ovr;
  assign err_frm = err.frm;
endmodule

// File: rtl/usart_data_reg_chk.sv
module usart_data_reg_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_rdata,
  input logic          char7,
  input logic          rx_ie,
  input logic          rx_done,
  input logic          err_clr,
  input logic          rx_full,
  input logic          rx_irq,
  input logic          err_par,
  input logic          err_ovr,
  input logic          err_frm,
  input logic [DW-1:0] tx_data,
  input logic          tx_full,
  input logic          tx_take
);
  // R2
  load_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done && !rx_full |=> rx_full);
  // R3
  top_bit_masked_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done && char7 && (!rx_full || bus_rd) |=> !bus_rdata[DW-1]);
  // R4
  read_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !rx_done |=> !rx_full && $stable(bus_rdata));
  // R5
  irq_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done && rx_ie && (!rx_full || bus_rd) |=> rx_irq);
  // R6
  irq_held_by_error_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq && (err_par || err_ovr || err_frm) |=> rx_irq);
  // R7
  overrun_keeps_buf_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done && rx_full && !bus_rd |=> err_ovr && $stable(bus_rdata));
  // R8
  errors_survive_read_chk: assert property (@(posedge clk) disable iff (rst)
    !err_clr && err_par |=> err_par);
  // R9
  read_and_load_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done && bus_rd && !err_ovr && !err_clr |=> rx_full && !err_ovr);
  // R10
  write_stored_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !tx_full |=> tx_full);
  // R11
  write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && tx_full |=> $stable(tx_data));
  // R11
  take_empties_chk: assert property (@(posedge clk) disable iff (rst)
    tx_take && tx_full |=> !tx_full);
endmodule

bind usart_data_reg usart_data_reg_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .char7(char7), .rx_ie(rx_ie), .rx_done(rx_done),
  .err_clr(err_clr), .rx_full(rx_full), .rx_irq(rx_irq), .err_par(err_par),
  .err_ovr(err_ovr), .err_frm(err_frm), .tx_data(tx_data),
  .tx_full(tx_full), .tx_take(tx_take)
);

// File: tb/tb_usart_data_reg.sv
`timescale 1ns/1ps
module tb_usart_data_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd = 0, wr = 0, c7 = 0, ie = 0, done = 0, perr = 0, ferr = 0, clr = 0, take = 0;
  logic [7:0] wdata = 0, ch = 0;
  logic [7:0] rdata, txd;
  logic       full, irq, epar, eovr, efrm, txf;

  int n_chk = 0, n_bad = 0;

  // model state
  logic [7:0] m_buf, m_txd;
  logic       m_full, m_irq, m_par, m_ovr, m_frm, m_txf;

  always #2 clk = ~clk;

  usart_data_reg dut (
    .clk(clk), .rst(rst), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .char7(c7), .rx_ie(ie), .rx_done(done), .rx_char(ch),
    .rx_perr(perr), .rx_ferr(ferr), .err_clr(clr), .rx_full(full),
    .rx_irq(irq), .err_par(epar), .err_ovr(eovr), .err_frm(efrm),
    .tx_data(txd), .tx_full(txf), .tx_take(take)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] stored(logic [7:0] c, logic m7);
    return m7 ? {1'b0, c[6:0]} : c;
  endfunction

  task automatic model_update();
    logic ld, ov, eany;
    if (rst) begin
      m_buf = 0; m_txd = 0; m_full = 0; m_irq = 0;
      m_par = 0; m_ovr = 0; m_frm = 0; m_txf = 0;
      return;
    end
    ld   = done && (!m_full || rd);
    ov   = done && m_full && !rd;
    eany = m_par | m_ovr | m_frm;
    if (ld && ie)                  m_irq = 1;
    else if (rd && ie && !eany)    m_irq = 0;
    if (ld) m_buf = stored(ch, c7);
    if (ld) m_full = 1; else if (rd) m_full = 0;
    m_par = (m_par & ~clr) | (ld & perr);
    m_frm = (m_frm & ~clr) | (ld & ferr);
    m_ovr = (m_ovr & ~clr) | ov;
    if (wr && !m_txf) begin m_txd = wdata; m_txf = 1; end
    else if (take)    m_txf = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R2 bus_rdata", rdata, m_buf);
    chk("R4 rx_full", {7'd0, full}, {7'd0, m_full});
    chk("R6 rx_irq", {7'd0, irq}, {7'd0, m_irq});
    chk("R7 err_ovr", {7'd0, eovr}, {7'd0, m_ovr});
    chk("R8 err_par", {7'd0, epar}, {7'd0, m_par});
    chk("R8 err_frm", {7'd0, efrm}, {7'd0, m_frm});
    chk("R10 tx_full", {7'd0, txf}, {7'd0, m_txf});
    chk("R11 tx_data", txd, m_txd);
  endtask

  task automatic idle();
    rd = 0; wr = 0; done = 0; perr = 0; ferr = 0; clr = 0; take = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(); step();
    rst = 0;
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 flags", {2'b0, full, irq, epar, eovr, efrm, txf}, 8'h00);
    chk("R1 tx_data", txd, 8'h00);

    // R2/R5 load with interrupt enabled
    ie = 1; done = 1; ch = 8'hA5; step(); idle();
    chk("R2 stored", rdata, 8'hA5);
    chk("R5 irq raised", {7'd0, irq}, 8'd1);
    // R7 overrun
    done = 1; ch = 8'h3C; step(); idle();
    chk("R7 buffer kept", rdata, 8'hA5);
    chk("R7 overrun set", {7'd0, eovr}, 8'd1);
    // R6 read with error pending keeps irq, R4 full cleared
    rd = 1; step(); idle();
    chk("R6 irq held", {7'd0, irq}, 8'd1);
    chk("R4 full cleared", {7'd0, full}, 8'd0);
    // R8 clear then read releases irq
    clr = 1; step(); idle();
    chk("R8 cleared", {7'd0, eovr}, 8'd0);
    rd = 1; step(); idle();
    chk("R6 irq released", {7'd0, irq}, 8'd0);
    // R3 7-bit mode, R5 no irq when disabled
    ie = 0; c7 = 1; done = 1; ch = 8'hFF; step(); idle();
    chk("R3 top bit", rdata, 8'h7F);
    chk("R5 no irq", {7'd0, irq}, 8'd0);
    c7 = 0;
    // R9 read and completion together
    rd = 1; done = 1; ch = 8'h81; step(); idle();
    chk("R9 new char", rdata, 8'h81);
    chk("R9 full kept", {7'd0, full}, 8'd1);
    chk("R9 no overrun", {7'd0, eovr}, 8'd0);
    // R8 error set and clear same cycle
    rd = 1; step(); idle();
    done = 1; perr = 1; clr = 1; ch = 8'h11; step(); idle();
    chk("R8 set wins", {7'd0, epar}, 8'd1);
    clr = 1; step(); idle();
    // R10 write, R11 write while full with take
    wr = 1; wdata = 8'h5A; step(); idle();
    chk("R10 tx loaded", txd, 8'h5A);
    chk("R10 rdata untouched", rdata, 8'h11);
    wr = 1; take = 1; wdata = 8'hC3; step(); idle();
    chk("R11 write ignored", txd, 8'h5A);
    chk("R11 take empties", {7'd0, txf}, 8'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      rd    = ($urandom % 3) == 0;
      wr    = ($urandom % 3) == 0;
      wdata = 8'($urandom);
      done  = ($urandom % 3) == 0;
      ch    = 8'($urandom);
      perr  = ($urandom % 6) == 0;
      ferr  = ($urandom % 6) == 0;
      clr   = ($urandom % 8) == 0;
      take  = ($urandom % 3) == 0;
      ie    = ($urandom % 4) != 0;
      c7    = ($urandom % 2) == 0;
      step();
    end
    idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule